// File: doc/BRIEF.md
# SPI EEPROM Page Write Sequencer

This block drives a serial EEPROM with 16-bit addressing through a byte-exchange SPI master. It has no shift register of its own. It hands one byte at a time to the master, waits for the exchanged byte to come back, and controls the chip-select line itself. A client starts a transfer by giving a direction, a start address and a byte count. Write data is taken from a FIFO-style source with a valid/pop pair. Read data comes out as one-cycle valid strobes.

Every accepted command starts with the same step: the sequencer reads the device status until the device reports that no write is in progress. For a write, it then sends a stand-alone write-enable frame, followed by one frame that carries the write opcode, the address and all the data bytes. For a read, it sends a single frame: the read opcode, the address, then one dummy byte per byte wanted.

A write that would run past the end of a 64-byte page is refused before any bus activity. If the device stays busy for too many status reads, the command ends with a fault.

Top module: `spi_page_seq`

## Requirements
- R1: While reset is held and right after it is released, `spi_cs_n` is 1, `spi_start`, `busy` and `done` are 0, and `cmd_ready` is 1.
- R2: Every accepted command first runs a status frame: chip select goes low, byte 0x05 is sent, then dummy bytes 0x00 are sent in the same frame until a returned byte has bit 0 equal to 0. Chip select then rises, and it is high for at least one cycle before the next frame.
- R3: A write sends the single byte 0x06 in a frame of its own, between the status frame and the write frame.
- R4: The write frame carries, in this order: 0x02, the address high byte, the address low byte, then `cmd_len` bytes taken from the write FIFO in FIFO order. After the last byte, chip select rises and `done` pulses for one cycle.
- R5: A command is refused when `cmd_len` is 0, or when it is a write with (address mod 64) + `cmd_len` > 64. A refused command makes no bus activity and pulses `done` together with `err_page`.
- R6: A read frame carries 0x03, the address high byte and the address low byte, then `cmd_len` dummy bytes 0x00. Each returned byte is presented on `rd_data` with a one-cycle `rd_valid`, in order. A read sends no 0x06 frame.
- R7: A read may run up to 127 bytes and across page boundaries without being split or refused.
- R8: If POLL_LIMIT status bytes in a row return bit 0 equal to 1, the command ends. Chip select rises, nothing else is sent, no FIFO byte is taken, and `done` pulses with `poll_fault`.
- R9: In the data phase of a write, no byte is sent while `wr_valid` is 0. The frame stays open, with chip select low, until data arrives.
- R10: A command is taken only while `cmd_ready` is 1. From acceptance until completion, `busy` is 1 and `cmd_ready` is 0, and `cmd_valid` is ignored.
- R11: The address is limited to the 32,768-byte device space: bit 15 of the address high byte is sent as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Start address |
| cmd_len | input | 7 | Byte count |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_page | output | 1 | Valid with done: command refused |
| poll_fault | output | 1 | Valid with done: status poll gave up |
| wr_data | input | 8 | Head of write FIFO |
| wr_valid | input | 1 | Write FIFO not empty |
| wr_pop | output | 1 | Consume head of write FIFO |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received in the exchange |

## Verification
Writes are exercised as a single byte, a full aligned page, a burst that ends exactly on a page edge, and an address with bit 15 set. Together these separate correct page arithmetic and address masking from off-by-one mistakes. Refused cases (a burst one byte past the page edge, an oversized length, a zero length) must produce no frame at all. Reads are tried at one byte, across a page boundary and at 70 bytes, with busy counts of zero to three status reads. The frame bytes and the read-back data are compared against a byte-level device model. A starved FIFO and a device that never becomes idle show that the data phase stalls rather than sending garbage, and that the poll counter cuts off at its limit.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 7;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_STATUS = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_EN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
    localparam logic [BYTE_W-1:0] FILL_BYTE = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL_OP, S_POLL_RD, S_POLL_GAP, S_WREN, S_WREN_GAP,
        S_CMD, S_ADDR_HI, S_ADDR_LO, S_DATA, S_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              waiting;
        logic              is_write;
        logic              timed_out;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              cs_n;
        logic              done;
        logic              err;
        logic              fault;
        logic [BYTE_W-1:0] rd_data;
        logic              rd_valid;
    } seq_regs_t;
endpackage

// File: rtl/spi_pw_page_check.sv
module spi_pw_page_check #(
    parameter int PAGE_BYTES = 64,
    parameter int LEN_W      = 7,
    localparam int PAGE_LOG  = $clog2(PAGE_BYTES),
    localparam int SUM_W     = ((LEN_W > PAGE_LOG) ? LEN_W : PAGE_LOG) + 1
) (
    input  logic [PAGE_LOG-1:0] offset,
    input  logic [LEN_W-1:0]    len,
    input  logic                is_write,
    output logic                ok
);
    logic [SUM_W-1:0] end_pos;

    always_comb begin
        end_pos = SUM_W'(offset) + SUM_W'(len);
        ok = (len != '0) && (!is_write || (end_pos <= SUM_W'(PAGE_BYTES)));
    end
endmodule

// File: rtl/spi_pw_poll_timer.sv
module spi_pw_poll_timer #(
    parameter int LIMIT   = 4096,
    localparam int CNT_W  = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic final_try
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (tick)
            count_d = count_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign final_try = (count_q == CNT_W'(LIMIT - 1));

    // R8: the busy-read count never reaches the limit; the sequencer stops one read earlier
    assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CNT_W'(LIMIT))
        else $error("poll counter exceeded limit");
endmodule

// File: rtl/spi_page_seq.sv
module spi_page_seq
    import spi_pw_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int DEV_ADDR_W = 15,
    parameter int POLL_LIMIT = 4096,
    localparam int PAGE_LOG  = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    output logic              busy,
    output logic              done,
    output logic              err_page,
    output logic              poll_fault,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_pop,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              spi_cs_n,
    output logic              spi_start,
    output logic [BYTE_W-1:0] spi_tx,
    input  logic              spi_done,
    input  logic [BYTE_W-1:0] spi_rx
);
    localparam logic [ADDR_W-1:0] DEV_MASK = ADDR_W'((1 << DEV_ADDR_W) - 1);

    seq_regs_t r_d, r_q;

    logic              req_ok;
    logic              poll_clr, poll_tick, poll_final;
    logic              in_byte, can_send, xfer_end;
    logic [BYTE_W-1:0] tx_sel;

    spi_pw_page_check #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) page_i (
        .offset  (cmd_addr[PAGE_LOG-1:0]),
        .len     (cmd_len),
        .is_write(cmd_write),
        .ok      (req_ok)
    );

    spi_pw_poll_timer #(.LIMIT(POLL_LIMIT)) poll_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clr),
        .tick     (poll_tick),
        .final_try(poll_final)
    );

    // byte to send in each byte-carrying state
    always_comb begin
        in_byte = 1'b1;
        tx_sel  = FILL_BYTE;
        unique case (r_q.state)
            S_POLL_OP: tx_sel = OP_STATUS;
            S_POLL_RD: tx_sel = FILL_BYTE;
            S_WREN:    tx_sel = OP_WR_EN;
            S_CMD:     tx_sel = r_q.is_write ? OP_WRITE : OP_READ;
            S_ADDR_HI: tx_sel = r_q.addr[ADDR_W-1 -: BYTE_W];
            S_ADDR_LO: tx_sel = r_q.addr[BYTE_W-1:0];
            S_DATA:    tx_sel = r_q.is_write ? wr_data : FILL_BYTE;
            default:   in_byte = 1'b0;
        endcase
        can_send = in_byte && ((r_q.state != S_DATA) || !r_q.is_write || wr_valid);
    end

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.err      = 1'b0;
        r_d.fault    = 1'b0;
        r_d.rd_valid = 1'b0;
        poll_clr     = 1'b0;
        poll_tick    = 1'b0;

        spi_start = can_send && !r_q.waiting;
        xfer_end  = r_q.waiting && spi_done;
        wr_pop    = spi_start && (r_q.state == S_DATA) && r_q.is_write;
        if (spi_start) r_d.waiting = 1'b1;
        if (xfer_end)  r_d.waiting = 1'b0;

        unique case (r_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (req_ok) begin
                        r_d.state     = S_POLL_OP;
                        r_d.cs_n      = 1'b0;
                        r_d.is_write  = cmd_write;
                        r_d.addr      = cmd_addr & DEV_MASK;
                        r_d.left      = cmd_len;
                        r_d.timed_out = 1'b0;
                        poll_clr      = 1'b1;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end
                end
            end
            S_POLL_OP: if (xfer_end) r_d.state = S_POLL_RD;
            S_POLL_RD: begin
                if (xfer_end) begin
                    if (!spi_rx[0]) begin
                        r_d.state = S_POLL_GAP;
                        r_d.cs_n  = 1'b1;
                    end else if (poll_final) begin
                        r_d.state     = S_FIN;
                        r_d.cs_n      = 1'b1;
                        r_d.timed_out = 1'b1;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            S_POLL_GAP: begin
                r_d.cs_n  = 1'b0;
                r_d.state = r_q.is_write ? S_WREN : S_CMD;
            end
            S_WREN: begin
                if (xfer_end) begin
                    r_d.state = S_WREN_GAP;
                    r_d.cs_n  = 1'b1;
                end
            end
            S_WREN_GAP: begin
                r_d.cs_n  = 1'b0;
                r_d.state = S_CMD;
            end
            S_CMD:     if (xfer_end) r_d.state = S_ADDR_HI;
            S_ADDR_HI: if (xfer_end) r_d.state = S_ADDR_LO;
            S_ADDR_LO: if (xfer_end) r_d.state = S_DATA;
            S_DATA: begin
                if (xfer_end) begin
                    if (!r_q.is_write) begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = spi_rx;
                    end
                    r_d.left = r_q.left - LEN_W'(1);
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.state = S_FIN;
                        r_d.cs_n  = 1'b1;
                    end
                end
            end
            S_FIN: begin
                r_d.done  = 1'b1;
                r_d.fault = r_q.timed_out;
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.state == S_IDLE);
    assign busy       = !cmd_ready;
    assign done       = r_q.done;
    assign err_page   = r_q.err;
    assign poll_fault = r_q.fault;
    assign rd_data    = r_q.rd_data;
    assign rd_valid   = r_q.rd_valid;
    assign spi_cs_n   = r_q.cs_n;
    assign spi_tx     = tx_sel;

    // R2: a byte exchange only starts inside an open frame
    assert_start_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> !spi_cs_n)
        else $error("byte started with chip select high");

    // R4: one byte in flight at a time
    assert_single_flight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start)
        else $error("back-to-back byte starts");

    // R1: an idle sequencer keeps the device deselected
    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> spi_cs_n)
        else $error("chip select low while idle");

    // R5: a refusal comes with done and without an open frame
    assert_refusal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_page |-> (done && spi_cs_n))
        else $error("refusal flag without done or with open frame");

    // R9: the FIFO is only popped when it holds data
    assert_pop_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> wr_valid)
        else $error("pop from empty write FIFO");

    // R6: read strobes follow a finished exchange
    assert_read_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(spi_done))
        else $error("read strobe without exchange");
endmodule

// File: tb/spi_page_seq_tb.sv
module spi_page_seq_tb_top;
    localparam int POLL_LIM = 6;
    localparam int NVEC     = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [6:0] cmd_len = '0;
    logic       cmd_ready, busy, done, err_page, poll_fault;
    logic [7:0] wr_data;
    logic       wr_valid, wr_pop;
    logic [7:0] rd_data;
    logic       rd_valid, spi_cs_n, spi_start;
    logic [7:0] spi_tx;
    logic       spi_done;
    logic [7:0] spi_rx;

    always #5 clk = ~clk;

    spi_page_seq #(.POLL_LIMIT(POLL_LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ready(cmd_ready), .busy(busy),
        .done(done), .err_page(err_page), .poll_fault(poll_fault),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .spi_cs_n(spi_cs_n),
        .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
    );

    // write FIFO: contents and write pointer owned by tasks, read pointer by the model
    logic [7:0] fifo_mem [256];
    logic [7:0] fifo_wr = '0;
    logic [7:0] fifo_rd;
    assign wr_valid = (fifo_rd != fifo_wr);
    assign wr_data  = fifo_mem[fifo_rd];

    // byte-exchange master plus device model
    int         wip_cfg = 0;
    logic [7:0] dev_mem [256];
    logic [7:0] log_b [512];
    int         log_f [512];
    logic [7:0] rd_log [256];
    int log_n, frame_no, rd_n, done_n, bidx, dly;
    logic       last_err, last_fault, cs_prev;
    logic [7:0] op, ah, rx_hold;
    logic [14:0] ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dev_mem[i] <= 8'(i) ^ 8'hA5;
            fifo_rd <= '0; log_n <= 0; frame_no <= 0; rd_n <= 0; done_n <= 0;
            bidx <= 0; dly <= 0; spi_done <= 1'b0; spi_rx <= '0; cs_prev <= 1'b1;
            last_err <= 1'b0; last_fault <= 1'b0; op <= '0; ah <= '0; ptr <= '0; rx_hold <= '0;
        end else begin
            cs_prev  <= spi_cs_n;
            spi_done <= 1'b0;
            if (!cs_prev && spi_cs_n) frame_no <= frame_no + 1;
            if (spi_cs_n) bidx <= 0;
            if (dly != 0) begin
                dly <= dly - 1;
                if (dly == 1) begin spi_done <= 1'b1; spi_rx <= rx_hold; end
            end
            if (wr_pop) fifo_rd <= fifo_rd + 8'd1;
            if (spi_start) begin
                log_b[log_n % 512] <= spi_tx;
                log_f[log_n % 512] <= frame_no;
                log_n <= log_n + 1;
                bidx  <= bidx + 1;
                dly   <= 2;
                rx_hold <= 8'h00;
                if (bidx == 0) op <= spi_tx;
                else if (op == 8'h05) rx_hold <= (bidx <= wip_cfg) ? 8'h01 : 8'h00;
                else if (bidx == 1) ah <= spi_tx;
                else if (bidx == 2) ptr <= {ah[6:0], spi_tx};
                else begin
                    if (op == 8'h03) rx_hold <= dev_mem[ptr[7:0]];
                    if (op == 8'h02) dev_mem[ptr[7:0]] <= spi_tx;
                    ptr <= ptr + 15'd1;
                end
            end
            if (rd_valid) begin rd_log[rd_n % 256] <= rd_data; rd_n <= rd_n + 1; end
            if (done) begin done_n <= done_n + 1; last_err <= err_page; last_fault <= poll_fault; end
        end
    end

    // bench bookkeeping
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] ref_mem [256];
    int b_log, b_frame, b_rd, b_done;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fifo_mem[fifo_wr] = b;
        fifo_wr = fifo_wr + 8'd1;
    endtask

    task automatic mark();
        b_log = log_n; b_frame = frame_no; b_rd = rd_n; b_done = done_n;
    endtask

    task automatic issue(input bit w, input logic [15:0] a, input logic [6:0] n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_len = n;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (done_n == b_done && t < 20000) begin @(negedge clk); t++; end
        check(done_n != b_done, {tag, " completion"}, done_n - b_done, 1);
    endtask

    // expected bytes of every frame, built from the requirements
    task automatic compare(input bit w, input logic [15:0] a, input int n, input int wip,
                           input bit tmo, input string tag);
        logic [7:0] eb [300];
        int ef [300];
        int k = 0, fr = 0, bad_at = -1;
        eb[k] = 8'h05; ef[k] = 0; k++;
        if (tmo) begin
            for (int i = 0; i < POLL_LIM; i++) begin eb[k] = 8'h00; ef[k] = 0; k++; end
            fr = 1;
        end else begin
            for (int i = 0; i <= wip; i++) begin eb[k] = 8'h00; ef[k] = 0; k++; end
            fr = 1;
            if (w) begin eb[k] = 8'h06; ef[k] = fr; k++; fr++; end
            eb[k] = w ? 8'h02 : 8'h03; ef[k] = fr; k++;
            eb[k] = {1'b0, a[14:8]}; ef[k] = fr; k++;
            eb[k] = a[7:0]; ef[k] = fr; k++;
            for (int i = 0; i < n; i++) begin
                eb[k] = w ? fifo_mem[8'(b_fifo + i)] : 8'h00; ef[k] = fr; k++;
            end
            fr++;
        end
        check(log_n - b_log == k, {tag, " byte count"}, log_n - b_log, k);
        for (int i = 0; i < k && i < log_n - b_log; i++)
            if (bad_at < 0 && (log_b[(b_log + i) % 512] != eb[i] || log_f[(b_log + i) % 512] - b_frame != ef[i]))
                bad_at = i;
        check(bad_at < 0, {tag, " frame contents"},
              (bad_at < 0) ? 0 : int'(log_b[(b_log + bad_at) % 512]),
              (bad_at < 0) ? 0 : int'(eb[bad_at]));
        check(frame_no - b_frame == fr, {tag, " frame count"}, frame_no - b_frame, fr);
        if (!tmo && w)
            for (int i = 0; i < n; i++) ref_mem[8'(a[7:0] + i)] = fifo_mem[8'(b_fifo + i)];
        if (!tmo && !w) begin
            int rb = -1;
            check(rd_n - b_rd == n, {tag, " read strobes"}, rd_n - b_rd, n);
            for (int i = 0; i < n; i++)
                if (rb < 0 && rd_log[(b_rd + i) % 256] != ref_mem[8'(a[7:0] + i)]) rb = i;
            check(rb < 0, {tag, " read data"}, rb, -1);
        end
    endtask

    logic [7:0] b_fifo;

    // vector: write, addr, len, wip reads, expect refusal
    localparam logic [28:0] VECS [NVEC] = '{
        {1'b1, 16'h0100, 7'd1,  4'd0, 1'b0},
        {1'b1, 16'h0140, 7'd64, 4'd2, 1'b0},
        {1'b1, 16'h003E, 7'd2,  4'd1, 1'b0},
        {1'b1, 16'h003F, 7'd2,  4'd0, 1'b1},
        {1'b1, 16'h8005, 7'd3,  4'd0, 1'b0},
        {1'b1, 16'h0000, 7'd65, 4'd0, 1'b1},
        {1'b1, 16'h0010, 7'd0,  4'd0, 1'b1},
        {1'b0, 16'h0100, 7'd1,  4'd0, 1'b0},
        {1'b0, 16'h7FFE, 7'd4,  4'd1, 1'b0},
        {1'b0, 16'h013E, 7'd70, 4'd3, 1'b0},
        {1'b0, 16'h0000, 7'd0,  4'd0, 1'b1}
    };

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'hA5;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1 && spi_start == 1'b0, "R1 cs/start in reset", {spi_cs_n, spi_start}, 2);
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1 && spi_cs_n == 1'b1, "R1 ready after reset", {cmd_ready, spi_cs_n}, 3);

        for (int v = 0; v < NVEC; v++) begin
            bit w; logic [15:0] a; int n, wip; bit e; string tag;
            w = VECS[v][28]; a = VECS[v][27:12]; n = int'(VECS[v][11:5]);
            wip = int'(VECS[v][4:1]); e = VECS[v][0];
            tag = $sformatf("vec%0d %s", v, w ? "R2 R3 R4 R11" : ((n > 64) ? "R2 R6 R7 R11" : "R2 R6 R11"));
            wip_cfg = wip;
            b_fifo = fifo_wr;
            if (w && !e) for (int i = 0; i < n; i++) push(8'(i * 7 + v * 31 + 3));
            mark();
            issue(w, a, 7'(n));
            if (!e) check(busy == 1'b1 && cmd_ready == 1'b0, {tag, " R10 busy after accept"}, {busy, cmd_ready}, 2);
            wait_done(tag);
            check(last_err == e, $sformatf("vec%0d R5 refusal flag", v), last_err, e);
            if (e) check(log_n == b_log && frame_no == b_frame, $sformatf("vec%0d R5 no bus activity", v), log_n - b_log, 0);
            else compare(w, a, n, wip, 1'b0, tag);
        end

        // R9 starved FIFO, R10 command while busy is ignored
        wip_cfg = 0;
        b_fifo = fifo_wr;
        push(8'h11); push(8'h22);
        mark();
        issue(1'b1, 16'h0200, 7'd4);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0000; cmd_len = 7'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (200) @(negedge clk);
        check(log_n - b_log == 8, "R9 bytes sent while starved", log_n - b_log, 8);
        check(spi_cs_n == 1'b0 && done_n == b_done, "R9 frame held open", {spi_cs_n, done_n - b_done}, 0);
        push(8'h33); push(8'h44);
        wait_done("R9");
        compare(1'b1, 16'h0200, 4, 0, 1'b0, "R9 R10 stalled write");
        repeat (40) @(negedge clk);
        check(done_n - b_done == 1 && cmd_ready == 1'b1, "R10 busy-time command ignored", done_n - b_done, 1);

        // R8 device never idle
        wip_cfg = 100;
        b_fifo = fifo_wr;
        push(8'h5A);
        mark();
        issue(1'b1, 16'h0300, 7'd1);
        wait_done("R8");
        check(last_fault == 1'b1 && last_err == 1'b0, "R8 fault flag", {last_fault, last_err}, 2);
        compare(1'b1, 16'h0300, 1, 0, 1'b1, "R8 timeout frame");
        check(fifo_rd != fifo_wr, "R8 FIFO byte left unused", int'(fifo_wr - fifo_rd), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule